// File: doc/BRIEF.md
# DMA Error Capture Register Unit

This unit records uncorrectable (UE) and correctable (CE) memory errors that occur during DMA transfers. Each error is presented for one cycle on an event port that gives the error class, whether the transfer was a read or a write, a translation-fault flag, a 16-bit byte mask, the faulting address, an 8-bit ECC syndrome and a block-transfer flag. The unit keeps one 64-bit status register per class and one fault address register that both classes share. The address register can be read at a second index.

The first error of a class is the primary error. It sets a primary flag and freezes its details: byte mask, doubleword offset, block flag, syndrome (CE only) and address. Any later error of that class, while a primary flag is still set, sets only a secondary summary flag. Software clears flags by writing 1 to them, which re-arms capture. Each class drives its own interrupt line, which stays high while any flag of that class is set.

Top module: `dma_err_capture`

## Requirements
- R1: Reset (synchronous, active high) clears both status registers, the address register, the read-data register and both interrupt lines to zero.
- R2: An error of a class whose primary flags are all clear sets the primary read flag (bit 62) or primary write flag (bit 61), and sets bit 56 if it is a UE with the translation flag. It loads the byte mask into bits 47:32, address bits 5:3 into bits 31:29 and the block flag into bit 23. For a CE it also loads the syndrome into bits 55:48. It loads the full address into the shared address register.
- R3: An error of a class that has a primary flag set sets only the secondary read flag (bit 59) or secondary write flag (bit 58), and bit 57 for a UE with the translation flag. It leaves the captured fields and the address register unchanged.
- R4: The CE status register never sets bits 57 or 56. The UE status register keeps bits 55:48 at zero.
- R5: A write to status index 0 (UE) or 1 (CE) clears exactly the flag bits (62, 61, 59, 58, 57, 56) that are written as 1. Written zeros and all captured field bits have no effect.
- R6: The address register is read-only. Writes to index 2 or 3 change nothing.
- R7: Register indices: 0 is the UE status, 1 is the CE status, 2 is the fault address (zero-extended to 64 bits), and 3 is an alias that returns the same address. Any other index reads zero.
- R8: When an error and a clearing write to the same class arrive in the same cycle, the clear is applied first and the error second. If the clear removes every primary flag, the error is captured as a new primary.
- R9: `irq_ue` / `irq_ce` is high in the cycle after any flag of that class becomes set, and stays high exactly while at least one flag of that class is set.
- R10: `reg_rdata` is registered. It shows the register selected by `reg_addr` at the previous clock edge, as that register stood before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | One-cycle error event strobe |
| err_is_ce | input | 1 | Error class: 1 = correctable, 0 = uncorrectable |
| err_is_write | input | 1 | Transfer direction: 1 = write, 0 = read |
| err_xlate | input | 1 | Translation fault accompanied the error (UE only) |
| err_bmask | input | BM_W | Byte mask of the failing transfer |
| err_addr | input | ADDR_W | Faulting address |
| err_synd | input | SYND_W | ECC syndrome (used by CE) |
| err_block | input | 1 | Failing transfer was a block operation |
| reg_addr | input | REG_IDX_W | Register index for reads and writes |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Write data (1 bits clear flags) |
| reg_rdata | output | 64 | Registered read data |
| irq_ue | output | 1 | Uncorrectable error interrupt |
| irq_ce | output | 1 | Correctable error interrupt |

## Verification
The bench builds the unit with a 40-bit fault address and a 3-bit register index. The narrower address shows that the address register zero-extends when read. The extra index bit makes indices 4 to 7 reachable, so the zero return for unmapped indices is tested alongside the alias. The vector table walks primary capture, secondary accumulation, the CE-only syndrome and a clear-all step. The directed tests cover clearing one flag at a time, a secondary flag left without a primary, a clear and an error in the same cycle, and reset in the middle of a run.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  // flag positions (software decodes these)
  localparam int unsigned B_P_RD  = 62;
  localparam int unsigned B_P_WR  = 61;
  localparam int unsigned B_S_RD  = 59;
  localparam int unsigned B_S_WR  = 58;
  localparam int unsigned B_S_XL  = 57;
  localparam int unsigned B_P_XL  = 56;
  // captured field positions
  localparam int unsigned SYND_LO = 48;
  localparam int unsigned BM_LO   = 32;
  localparam int unsigned OFF_LO  = 29;
  localparam int unsigned B_BLK   = 23;
  localparam int unsigned BM_W    = 16;
  localparam int unsigned SYND_W  = 8;
  localparam int unsigned OFF_W   = 3;
  localparam int unsigned REG_W   = 64;
  // register indices
  localparam int unsigned IDX_UE    = 0;
  localparam int unsigned IDX_CE    = 1;
  localparam int unsigned IDX_ADDR  = 2;
  localparam int unsigned IDX_ALIAS = 3;
  // clear vector layout: {p_rd, p_wr, s_rd, s_wr, s_xl, p_xl}
  typedef logic [5:0] clr_vec_t;
endpackage

// File: rtl/dma_err_bank.sv
module dma_err_bank
  import dma_err_pkg::*;
#(
  parameter bit HAS_XLATE = 1'b1,
  parameter bit HAS_SYND  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_hit,
  input  logic              ev_write,
  input  logic              ev_xlate,
  input  logic [BM_W-1:0]   ev_bmask,
  input  logic [OFF_W-1:0]  ev_off,
  input  logic              ev_block,
  input  logic [SYND_W-1:0] ev_synd,
  input  logic              clr_en,
  input  clr_vec_t          clr_vec,
  output logic [REG_W-1:0]  status,
  output logic              capture,
  output logic              irq
);
  logic p_rd, p_wr, p_xl, s_rd, s_wr, s_xl;
  logic [BM_W-1:0]   bm_q;
  logic [OFF_W-1:0]  off_q;
  logic              blk_q;
  logic [SYND_W-1:0] syn_q;

  logic c_prd, c_pwr, c_pxl, c_srd, c_swr, c_sxl;
  logic n_prd, n_pwr, n_pxl, n_srd, n_swr, n_sxl;
  logic prim_free, xl_in;
  clr_vec_t clr_m;

  assign clr_m = clr_en ? clr_vec : '0;
  assign xl_in = ev_xlate & HAS_XLATE;

  always_comb begin
    // clear applies first, new event on top
    c_prd = p_rd & ~clr_m[5];
    c_pwr = p_wr & ~clr_m[4];
    c_srd = s_rd & ~clr_m[3];
    c_swr = s_wr & ~clr_m[2];
    c_sxl = s_xl & ~clr_m[1];
    c_pxl = p_xl & ~clr_m[0];
    prim_free = ~(c_prd | c_pwr | c_pxl);
    capture = ev_hit & prim_free;
    n_prd = c_prd | (capture & ~ev_write);
    n_pwr = c_pwr | (capture &  ev_write);
    n_pxl = c_pxl | (capture &  xl_in);
    n_srd = c_srd | (ev_hit & ~prim_free & ~ev_write);
    n_swr = c_swr | (ev_hit & ~prim_free &  ev_write);
    n_sxl = c_sxl | (ev_hit & ~prim_free &  xl_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {p_rd, p_wr, p_xl, s_rd, s_wr, s_xl} <= '0;
      bm_q  <= '0;
      off_q <= '0;
      blk_q <= 1'b0;
      syn_q <= '0;
      irq   <= 1'b0;
    end else begin
      {p_rd, p_wr, p_xl, s_rd, s_wr, s_xl} <= {n_prd, n_pwr, n_pxl, n_srd, n_swr, n_sxl};
      irq <= n_prd | n_pwr | n_pxl | n_srd | n_swr | n_sxl;
      if (capture) begin
        bm_q  <= ev_bmask;
        off_q <= ev_off;
        blk_q <= ev_block;
        syn_q <= HAS_SYND ? ev_synd : '0;
      end
    end
  end

  always_comb begin
    status = '0;
    status[B_P_RD] = p_rd;
    status[B_P_WR] = p_wr;
    status[B_S_RD] = s_rd;
    status[B_S_WR] = s_wr;
    status[B_S_XL] = s_xl;
    status[B_P_XL] = p_xl;
    status[SYND_LO +: SYND_W] = syn_q;
    status[BM_LO +: BM_W]     = bm_q;
    status[OFF_LO +: OFF_W]   = off_q;
    status[B_BLK]             = blk_q;
  end
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dma_err_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned REG_IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 err_valid,
  input  logic                 err_is_ce,
  input  logic                 err_is_write,
  input  logic                 err_xlate,
  input  logic [BM_W-1:0]      err_bmask,
  input  logic [ADDR_W-1:0]    err_addr,
  input  logic [SYND_W-1:0]    err_synd,
  input  logic                 err_block,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic                 reg_we,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq_ue,
  output logic                 irq_ce
);
  localparam int unsigned NCLS = 2;
  localparam logic [REG_IDX_W-1:0] IX_UE = REG_IDX_W'(IDX_UE);
  localparam logic [REG_IDX_W-1:0] IX_CE = REG_IDX_W'(IDX_CE);
  localparam logic [REG_IDX_W-1:0] IX_AD = REG_IDX_W'(IDX_ADDR);
  localparam logic [REG_IDX_W-1:0] IX_AL = REG_IDX_W'(IDX_ALIAS);

  logic [REG_W-1:0]  bank_stat [NCLS];
  logic [NCLS-1:0]   bank_cap, bank_irq;
  logic [REG_W-1:0]  ue_stat, ce_stat;
  logic [ADDR_W-1:0] addr_q;
  clr_vec_t          clr_vec;
  logic              unused_wdata;

  assign clr_vec = {reg_wdata[B_P_RD], reg_wdata[B_P_WR], reg_wdata[B_S_RD],
                    reg_wdata[B_S_WR], reg_wdata[B_S_XL], reg_wdata[B_P_XL]};
  assign unused_wdata = ^{reg_wdata[63], reg_wdata[60], reg_wdata[55:0]};

  for (genvar c = 0; c < NCLS; c++) begin : g_bank
    localparam bit IS_CE = (c == 1);
    localparam logic [REG_IDX_W-1:0] MY_IX = IS_CE ? IX_CE : IX_UE;
    dma_err_bank #(
      .HAS_XLATE(!IS_CE),
      .HAS_SYND (IS_CE)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .ev_hit  (err_valid && (err_is_ce == IS_CE)),
      .ev_write(err_is_write),
      .ev_xlate(err_xlate),
      .ev_bmask(err_bmask),
      .ev_off  (err_addr[5:3]),
      .ev_block(err_block),
      .ev_synd (err_synd),
      .clr_en  (reg_we && (reg_addr == MY_IX)),
      .clr_vec (clr_vec),
      .status  (bank_stat[c]),
      .capture (bank_cap[c]),
      .irq     (bank_irq[c])
    );
  end

  assign ue_stat = bank_stat[0];
  assign ce_stat = bank_stat[1];
  assign irq_ue  = bank_irq[0];
  assign irq_ce  = bank_irq[1];

  // shared fault address: loaded by a primary capture of either class
  always_ff @(posedge clk) begin
    if (rst)           addr_q <= '0;
    else if (|bank_cap) addr_q <= err_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        IX_UE:        reg_rdata <= ue_stat;
        IX_CE:        reg_rdata <= ce_stat;
        IX_AD, IX_AL: reg_rdata <= REG_W'(addr_q);
        default:      reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_err_capture_chk.sv
module dma_err_capture_chk #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned REG_IDX_W = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 err_valid,
  input logic                 err_is_ce,
  input logic [REG_IDX_W-1:0] reg_addr,
  input logic                 reg_we,
  input logic [63:0]          reg_wdata,
  input logic [63:0]          reg_rdata,
  input logic                 irq_ue,
  input logic                 irq_ce,
  input logic [63:0]          ue_stat,
  input logic [63:0]          ce_stat,
  input logic [ADDR_W-1:0]    addr_q
);
  localparam logic [REG_IDX_W-1:0] IX_UE = REG_IDX_W'(0);
  localparam logic [REG_IDX_W-1:0] IX_AL = REG_IDX_W'(3);

  assert_ue_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !err_is_ce) |=> irq_ue);

  assert_ce_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_is_ce) |=> irq_ce);

  // R3: captured UE fields frozen while a primary flag holds and no clear
  assert_fields_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    ((ue_stat[62] || ue_stat[61] || ue_stat[56]) && !(reg_we && reg_addr == IX_UE))
    |=> ($stable(ue_stat[47:29]) && $stable(ue_stat[23])));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !err_valid |=> $stable(addr_q));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == IX_UE && reg_wdata[62] && !err_valid) |=> !ue_stat[62]);

  assert_alias_read_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == IX_AL) |=> (reg_rdata == 64'($past(addr_q))));

  assert_ce_no_xlate_R4: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> (ce_stat[57:56] == 2'b00));
endmodule

bind dma_err_capture dma_err_capture_chk #(
  .ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W)
) u_chk (.*);

// File: tb/dma_err_capture_test.sv
module dma_err_capture_test;
  localparam int unsigned AW = 40;
  localparam int unsigned IW = 3;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          err_valid = 0, err_is_ce = 0, err_is_write = 0, err_xlate = 0, err_block = 0;
  logic [15:0]   err_bmask = '0;
  logic [AW-1:0] err_addr = '0;
  logic [7:0]    err_synd = '0;
  logic [IW-1:0] reg_addr = '0;
  logic          reg_we = 0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic          irq_ue, irq_ce;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dma_err_capture #(.ADDR_W(AW), .REG_IDX_W(IW)) uut (.*);

  typedef struct packed {
    logic          clr;
    logic          ce;
    logic          wr;
    logic          xl;
    logic [15:0]   bm;
    logic [AW-1:0] addr;
    logic [7:0]    syn;
    logic          blk;
    logic [63:0]   e_ue;
    logic [63:0]   e_ce;
    logic [AW-1:0] e_addr;
    logic          e_iue;
    logic          e_ice;
  } vec_t;

  localparam vec_t VECS [6] = '{
    // R2: first UE read captures primary and fields (syndrome ignored)
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h00F0, 40'h12_3456_7898, 8'hAA, 1'b1,
      64'h4000_00F0_6080_0000, 64'h0, 40'h12_3456_7898, 1'b1, 1'b0},
    // R3: second UE write with translation goes secondary only
    '{1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, 40'h00_0000_0038, 8'h00, 1'b0,
      64'h4600_00F0_6080_0000, 64'h0, 40'h12_3456_7898, 1'b1, 1'b0},
    // R2/R4: first CE write loads syndrome, ignores translation flag
    '{1'b0, 1'b1, 1'b1, 1'b1, 16'h0F0F, 40'h00_ABCD_0028, 8'h5A, 1'b0,
      64'h4600_00F0_6080_0000, 64'h205A_0F0F_A000_0000, 40'h00_ABCD_0028, 1'b1, 1'b1},
    // R3: second CE read is secondary
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h1111, 40'h00_0000_0040, 8'h33, 1'b1,
      64'h4600_00F0_6080_0000, 64'h285A_0F0F_A000_0000, 40'h00_ABCD_0028, 1'b1, 1'b1},
    // R5: clear all flags; fields of CE remain; UE recaptures
    '{1'b1, 1'b0, 1'b1, 1'b1, 16'h8001, 40'hFF_FFFF_FFF8, 8'h00, 1'b0,
      64'h2100_8001_E000_0000, 64'h005A_0F0F_A000_0000, 40'hFF_FFFF_FFF8, 1'b1, 1'b0},
    // R2: clear all, CE read capture
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0001, 40'h00_0000_0008, 8'hFF, 1'b1,
      64'h0000_8001_E000_0000, 64'h40FF_0001_2080_0000, 40'h00_0000_0008, 1'b0, 1'b1}
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_ev(input logic ce, input logic wr, input logic xl, input logic [15:0] bm,
                        input logic [AW-1:0] a, input logic [7:0] sy, input logic blk);
    err_valid = 1; err_is_ce = ce; err_is_write = wr; err_xlate = xl;
    err_bmask = bm; err_addr = a; err_synd = sy; err_block = blk;
  endtask

  task automatic ev(input logic ce, input logic wr, input logic xl, input logic [15:0] bm,
                    input logic [AW-1:0] a, input logic [7:0] sy, input logic blk);
    set_ev(ce, wr, xl, bm, a, sy, blk);
    cyc();
    err_valid = 0;
  endtask

  task automatic wr(input logic [IW-1:0] idx, input logic [63:0] d);
    reg_addr = idx; reg_wdata = d; reg_we = 1;
    cyc();
    reg_we = 0;
  endtask

  task automatic rd(input logic [IW-1:0] idx, output logic [63:0] d);
    reg_addr = idx;
    cyc();
    d = reg_rdata;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    rd(0, d); check("R1 ue after reset", d, 64'h0);
    rd(1, d); check("R1 ce after reset", d, 64'h0);
    rd(2, d); check("R1 addr after reset", d, 64'h0);
    check("R1 irq after reset", {62'h0, irq_ue, irq_ce}, 64'h0);

    foreach (VECS[i]) begin
      if (VECS[i].clr) begin
        wr(0, ALL1);
        wr(1, ALL1);
      end
      ev(VECS[i].ce, VECS[i].wr, VECS[i].xl, VECS[i].bm, VECS[i].addr, VECS[i].syn, VECS[i].blk);
      check($sformatf("R9 vec%0d irq", i), {62'h0, irq_ue, irq_ce}, {62'h0, VECS[i].e_iue, VECS[i].e_ice});
      rd(0, d); check($sformatf("R2/R3 vec%0d ue", i), d, VECS[i].e_ue);
      rd(1, d); check($sformatf("R2/R4 vec%0d ce", i), d, VECS[i].e_ce);
      rd(2, d); check($sformatf("R6 vec%0d addr", i), d, 64'(VECS[i].e_addr));
    end

    // R7: alias and unmapped index
    rd(3, d); check("R7 alias", d, 64'h8);
    rd(5, d); check("R7 unmapped", d, 64'h0);

    // R6: address writes ignored
    wr(2, ALL1);
    wr(3, ALL1);
    rd(2, d); check("R6 addr write ignored", d, 64'h8);

    // R5: ones at non-flag or unset flag positions change nothing
    wr(1, 64'h0800_0000_0000_0000);
    wr(1, 64'h00FF_FFFF_FFFF_FFFF);
    rd(1, d); check("R5 ce untouched", d, 64'h40FF_0001_2080_0000);

    // R3/R9: secondary left without primary, then new primary capture
    wr(1, ALL1);
    ev(0, 0, 0, 16'h0003, 40'h10, 8'h0, 0);
    ev(0, 1, 0, 16'h7777, 40'h18, 8'h0, 1);
    wr(0, 64'h4000_0000_0000_0000);
    rd(0, d); check("R5 partial clear", d, 64'h0400_0003_4000_0000);
    check("R9 irq on secondary only", {63'h0, irq_ue}, 64'h1);
    ev(0, 0, 1, 16'h00C0, 40'h30, 8'h0, 1);
    rd(0, d); check("R3 recapture after primary cleared", d, 64'h4500_00C0_C080_0000);
    rd(2, d); check("R2 addr recapture", d, 64'h30);

    // R8: clear and error in the same cycle
    set_ev(0, 1, 0, 16'h5555, 40'h20, 8'h0, 0);
    reg_addr = 0; reg_wdata = ALL1; reg_we = 1;
    cyc();
    err_valid = 0; reg_we = 0;
    rd(0, d); check("R8 collision ue", d, 64'h2000_5555_8000_0000);
    rd(2, d); check("R8 collision addr", d, 64'h20);

    // R10: read data is registered
    rd(0, d);
    reg_addr = 5;
    #2;
    check("R10 rdata holds before edge", reg_rdata, 64'h2000_5555_8000_0000);
    cyc();
    check("R10 rdata after edge", reg_rdata, 64'h0);

    // R9: interrupts drop when all flags cleared
    wr(0, ALL1);
    wr(1, ALL1);
    check("R9 irq cleared", {62'h0, irq_ue, irq_ce}, 64'h0);

    // R1: reset mid-run
    ev(1, 0, 0, 16'h1234, 40'h99, 8'h11, 1);
    rst = 1;
    cyc();
    rst = 0;
    check("R1 irq after mid reset", {62'h0, irq_ue, irq_ce}, 64'h0);
    rd(1, d); check("R1 ce after mid reset", d, 64'h0);
    rd(2, d); check("R1 addr after mid reset", d, 64'h0);

    summary();
  end
endmodule